// File: doc/BRIEF.md
# Clustered Segment-Bus Forward Port

This block is the left-to-right half of a shared attachment point that lets a small group of neighbouring modules sit on a segmented bus as one unit. The cluster members have consecutive bus addresses starting at `BASE`, and module index 0 is the leftmost. Each cycle, every module may present a pending request. The request carries a destination address, a data word, a valid flag and a readiness flag. An incoming transaction may also arrive from the bus segment on the left.

The block does three things in parallel. Requests aimed at a cluster member further to the right travel over direct links inside the cluster, and each destination admits one source. Requests aimed beyond the cluster compete for the single bus slot, and the leftmost one wins. The winner then goes through ordinary segment access control: incoming traffic addressed to any member is consumed and delivered to that member, and traffic addressed elsewhere passes through and pre-empts the cluster's own transmission. All outputs are registered, so results appear one clock after the inputs that caused them. A requester that gets no grant keeps its request asserted and tries again later.

Top module: `cbf_fwd_unit`

## Requirements
- R1: While reset is high, every grant, every delivery valid and the downstream valid are low one clock later. Reset is synchronous and active high.
- R2: A valid, ready request whose destination is `BASE+j` from source i < j is delivered to member j one clock later, with the source's data on `dlv_dat_o[j]`, and `gnt_o[i]` rises in the same cycle.
- R3: When several sources target the same member, only the lowest-index source is delivered and granted. Requests to different members are all served in the same cycle.
- R4: A request is never granted or delivered if it is not both valid and ready, or if its destination is in the cluster at or left of the source, or if its destination is below `BASE`.
- R5: Among valid, ready requests with destination at or above `BASE+N`, at most one is granted per cycle, and it is the lowest-index one.
- R6: An upstream transaction with address `BASE+j` is delivered to member j with the upstream data, and it is not forwarded downstream.
- R7: When the bus delivers to member j, every in-cluster request to member j is held without a grant. In-cluster requests to other members are unaffected.
- R8: An upstream transaction whose address is outside the cluster is forwarded downstream unchanged, and no outgoing cluster request is granted that cycle.
- R9: When the upstream is idle or hits the cluster, the selected outgoing request drives the downstream valid, address and data.
- R10: In-cluster deliveries and one outgoing bus transfer are granted in the same cycle when they involve different sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | N | Pending request per member |
| req_rdy | input | N | Request is ready to be considered |
| req_dst | input | N*AW | Destination address per member |
| req_dat | input | N*DW | Data word per member |
| up_vld | input | 1 | Upstream segment carries a transaction |
| up_addr | input | AW | Upstream destination address |
| up_dat | input | DW | Upstream data |
| gnt_o | output | N | Request sent, per source member |
| dlv_vld_o | output | N | Transaction delivered, per destination member |
| dlv_dat_o | output | N*DW | Delivered data per destination member |
| dn_vld_o | output | 1 | Downstream segment valid |
| dn_addr_o | output | AW | Downstream address |
| dn_dat_o | output | DW | Downstream data |

## Verification
The hardest situation to create is a single cycle in which all three paths interact. In that cycle an upstream hit takes one member, a local request collides with the hit at that same member, another local request reaches a free member, and two outgoing requests compete for the downstream slot. A single wrong precedence decision in that cycle would be hidden by the other paths. The vector table therefore has rows that stack these conditions. Each row lists the expected grant mask, delivery mask and downstream address, worked out from the priority rules. Directed steps then check the data routing and a reset applied while every input is active.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  // origin of a delivery into a cluster member
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_BUS   = 2'd1,
    SRC_LOCAL = 2'd2
  } dlv_src_e;
endpackage

// File: rtl/cbf_local_route.sv
module cbf_local_route #(
  parameter int N    = 3,
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int BASE = 16
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][AW-1:0] dst,
  input  logic [N-1:0][DW-1:0] dat,
  input  logic [N-1:0]         hit_oh,
  output logic [N-1:0]         lgnt,
  output logic [N-1:0]         ldlv,
  output logic [N-1:0][DW-1:0] ldat
);
  // one fixed-priority pick per destination, leftmost source first
  always_comb begin
    lgnt = '0;
    ldlv = '0;
    ldat = '0;
    for (int j = 0; j < N; j++) begin
      logic          found;
      logic [N-1:0]  sel;
      logic [DW-1:0] pick;
      found = 1'b0;
      sel   = '0;
      pick  = '0;
      for (int i = 0; i < N; i++) begin
        if (i < j && !found && cand[i] && dst[i] == AW'(BASE + j)) begin
          found  = 1'b1;
          sel[i] = 1'b1;
          pick   = dat[i];
        end
      end
      if (found && !hit_oh[j]) begin
        ldlv[j] = 1'b1;
        ldat[j] = pick;
        lgnt    = lgnt | sel;
      end
    end
  end
endmodule

// File: rtl/cbf_src_pick.sv
module cbf_src_pick #(
  parameter int N    = 3,
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int BASE = 16
) (
  input  logic [N-1:0]         cand,
  input  logic [N-1:0][AW-1:0] dst,
  input  logic [N-1:0][DW-1:0] dat,
  output logic [N-1:0]         pick_oh,
  output logic                 pick_any,
  output logic [AW-1:0]        pick_dst,
  output logic [DW-1:0]        pick_dat
);
  localparam logic [AW-1:0] LIM = AW'(BASE + N);

  logic [N-1:0] ext;

  always_comb begin
    for (int i = 0; i < N; i++) ext[i] = cand[i] && (dst[i] >= LIM);
  end

  // leftmost outgoing request wins; depends on local state only
  always_comb begin
    pick_oh  = '0;
    pick_any = 1'b0;
    pick_dst = '0;
    pick_dat = '0;
    for (int i = 0; i < N; i++) begin
      if (ext[i] && !pick_any) begin
        pick_any   = 1'b1;
        pick_oh[i] = 1'b1;
        pick_dst   = dst[i];
        pick_dat   = dat[i];
      end
    end
  end
endmodule

// File: rtl/cbf_bus_ctl.sv
module cbf_bus_ctl #(
  parameter int N    = 3,
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int BASE = 16
) (
  input  logic          up_vld,
  input  logic [AW-1:0] up_addr,
  input  logic [DW-1:0] up_dat,
  input  logic          pick_any,
  input  logic [AW-1:0] pick_dst,
  input  logic [DW-1:0] pick_dat,
  output logic [N-1:0]  hit_oh,
  output logic          send,
  output logic          nx_vld,
  output logic [AW-1:0] nx_addr,
  output logic [DW-1:0] nx_dat
);
  logic pass;

  // every member address counts as a hit for this unit
  always_comb begin
    for (int j = 0; j < N; j++) hit_oh[j] = up_vld && (up_addr == AW'(BASE + j));
  end

  assign pass    = up_vld && !(|hit_oh);
  assign send    = pick_any && !pass;
  assign nx_vld  = pass || send;
  assign nx_addr = pass ? up_addr : (send ? pick_dst : '0);
  assign nx_dat  = pass ? up_dat  : (send ? pick_dat : '0);
endmodule

// File: rtl/cbf_fwd_unit.sv
module cbf_fwd_unit
  import cbf_pkg::*;
#(
  parameter int N    = 3,
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int BASE = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         req_vld,
  input  logic [N-1:0]         req_rdy,
  input  logic [N-1:0][AW-1:0] req_dst,
  input  logic [N-1:0][DW-1:0] req_dat,
  input  logic                 up_vld,
  input  logic [AW-1:0]        up_addr,
  input  logic [DW-1:0]        up_dat,
  output logic [N-1:0]         gnt_o,
  output logic [N-1:0]         dlv_vld_o,
  output logic [N-1:0][DW-1:0] dlv_dat_o,
  output logic                 dn_vld_o,
  output logic [AW-1:0]        dn_addr_o,
  output logic [DW-1:0]        dn_dat_o
);
  logic [N-1:0]         cand;
  logic [N-1:0]         hit_oh, lgnt, ldlv, pick_oh;
  logic [N-1:0][DW-1:0] ldat;
  logic                 pick_any, send, nx_vld;
  logic [AW-1:0]        pick_dst, nx_addr;
  logic [DW-1:0]        pick_dat, nx_dat;
  dlv_src_e             src [N];
  logic [N-1:0]         gnt_n, dlv_n;
  logic [N-1:0][DW-1:0] dat_n;

  assign cand = req_vld & req_rdy;

  cbf_local_route #(.N(N), .AW(AW), .DW(DW), .BASE(BASE)) u_route (
    .cand(cand), .dst(req_dst), .dat(req_dat), .hit_oh(hit_oh),
    .lgnt(lgnt), .ldlv(ldlv), .ldat(ldat)
  );

  cbf_src_pick #(.N(N), .AW(AW), .DW(DW), .BASE(BASE)) u_pick (
    .cand(cand), .dst(req_dst), .dat(req_dat),
    .pick_oh(pick_oh), .pick_any(pick_any), .pick_dst(pick_dst), .pick_dat(pick_dat)
  );

  cbf_bus_ctl #(.N(N), .AW(AW), .DW(DW), .BASE(BASE)) u_bus (
    .up_vld(up_vld), .up_addr(up_addr), .up_dat(up_dat),
    .pick_any(pick_any), .pick_dst(pick_dst), .pick_dat(pick_dat),
    .hit_oh(hit_oh), .send(send), .nx_vld(nx_vld), .nx_addr(nx_addr), .nx_dat(nx_dat)
  );

  // bus delivery outranks local links at the same member
  always_comb begin
    gnt_n = lgnt | (pick_oh & {N{send}});
    for (int j = 0; j < N; j++) begin
      src[j] = hit_oh[j] ? SRC_BUS : (ldlv[j] ? SRC_LOCAL : SRC_NONE);
      dlv_n[j] = (src[j] != SRC_NONE);
      unique case (src[j])
        SRC_BUS:   dat_n[j] = up_dat;
        SRC_LOCAL: dat_n[j] = ldat[j];
        default:   dat_n[j] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_o     <= '0;
      dlv_vld_o <= '0;
      dlv_dat_o <= '0;
      dn_vld_o  <= 1'b0;
      dn_addr_o <= '0;
      dn_dat_o  <= '0;
    end else begin
      gnt_o     <= gnt_n;
      dlv_vld_o <= dlv_n;
      dlv_dat_o <= dat_n;
      dn_vld_o  <= nx_vld;
      dn_addr_o <= nx_addr;
      dn_dat_o  <= nx_dat;
    end
  end
endmodule

// File: rtl/cbf_fwd_chk.sv
module cbf_fwd_chk #(
  parameter int N    = 3,
  parameter int AW   = 8,
  parameter int DW   = 16,
  parameter int BASE = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [N-1:0]         req_vld,
  input logic [N-1:0]         req_rdy,
  input logic [N-1:0][AW-1:0] req_dst,
  input logic                 up_vld,
  input logic [AW-1:0]        up_addr,
  input logic [DW-1:0]        up_dat,
  input logic [N-1:0]         gnt_o,
  input logic [N-1:0]         dlv_vld_o,
  input logic [N-1:0][DW-1:0] dlv_dat_o,
  input logic                 dn_vld_o,
  input logic [AW-1:0]        dn_addr_o,
  input logic [DW-1:0]        dn_dat_o
);
  localparam logic [AW-1:0] LO = AW'(BASE);
  localparam logic [AW-1:0] HI = AW'(BASE + N);

  logic [N-1:0] ext_now;
  logic         miss_now;

  always_comb begin
    for (int i = 0; i < N; i++) ext_now[i] = req_vld[i] && req_rdy[i] && (req_dst[i] >= HI);
  end
  assign miss_now = up_vld && !(up_addr >= LO && up_addr < HI);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (gnt_o == '0 && dlv_vld_o == '0 && !dn_vld_o));

  // R5
  one_outgoing_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_o & $past(ext_now)));

  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && miss_now) |-> (dn_vld_o && dn_addr_o == $past(up_addr)
                                 && dn_dat_o == $past(up_dat)
                                 && (gnt_o & $past(ext_now)) == '0));

  generate
    for (genvar g = 0; g < N; g++) begin : g_mem
      // R4
      gnt_needs_ready_chk: assert property (@(posedge clk) disable iff (rst)
        gnt_o[g] |-> $past(req_vld[g] && req_rdy[g]));

      // R6
      bus_hit_dlv_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && up_vld && up_addr == AW'(BASE + g))
          |-> (dlv_vld_o[g] && dlv_dat_o[g] == $past(up_dat)));
    end
  endgenerate
endmodule

bind cbf_fwd_unit cbf_fwd_chk #(.N(N), .AW(AW), .DW(DW), .BASE(BASE)) u_chk (
  .clk(clk), .rst(rst), .req_vld(req_vld), .req_rdy(req_rdy), .req_dst(req_dst),
  .up_vld(up_vld), .up_addr(up_addr), .up_dat(up_dat),
  .gnt_o(gnt_o), .dlv_vld_o(dlv_vld_o), .dlv_dat_o(dlv_dat_o),
  .dn_vld_o(dn_vld_o), .dn_addr_o(dn_addr_o), .dn_dat_o(dn_dat_o)
);

// File: tb/test_cbf_fwd_unit.sv
module test_cbf_fwd_unit;
  localparam int N = 3;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int BASE = 16;
  localparam time CLK_PERIOD = 10;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic [N-1:0]         req_vld = '0, req_rdy = '0;
  logic [N-1:0][AW-1:0] req_dst = '0;
  logic [N-1:0][DW-1:0] req_dat = '0;
  logic                 up_vld = 1'b0;
  logic [AW-1:0]        up_addr = '0;
  logic [DW-1:0]        up_dat = '0;
  logic [N-1:0]         gnt_o, dlv_vld_o;
  logic [N-1:0][DW-1:0] dlv_dat_o;
  logic                 dn_vld_o;
  logic [AW-1:0]        dn_addr_o;
  logic [DW-1:0]        dn_dat_o;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cbf_fwd_unit #(.N(N), .AW(AW), .DW(DW), .BASE(BASE)) i_cbf_fwd_unit (
    .clk(clk), .rst(rst), .req_vld(req_vld), .req_rdy(req_rdy), .req_dst(req_dst),
    .req_dat(req_dat), .up_vld(up_vld), .up_addr(up_addr), .up_dat(up_dat),
    .gnt_o(gnt_o), .dlv_vld_o(dlv_vld_o), .dlv_dat_o(dlv_dat_o),
    .dn_vld_o(dn_vld_o), .dn_addr_o(dn_addr_o), .dn_dat_o(dn_dat_o)
  );

  typedef struct packed {
    logic [2:0] v; logic [2:0] r;
    logic [7:0] d0; logic [7:0] d1; logic [7:0] d2;
    logic uv; logic [7:0] ua;
    logic [2:0] eg; logic [2:0] ed; logic en; logic [7:0] ea;
  } vec_t;

  // members at 0x10..0x12; 0x30 and above are outgoing, 0x05 is below the cluster
  localparam vec_t TBL [12] = '{
    '{3'b001, 3'b001, 8'h12, 8'h00, 8'h00, 1'b0, 8'h00, 3'b001, 3'b100, 1'b0, 8'h00}, // R2
    '{3'b011, 3'b011, 8'h12, 8'h12, 8'h00, 1'b0, 8'h00, 3'b001, 3'b100, 1'b0, 8'h00}, // R3
    '{3'b011, 3'b011, 8'h11, 8'h12, 8'h00, 1'b0, 8'h00, 3'b011, 3'b110, 1'b0, 8'h00}, // R3
    '{3'b110, 3'b110, 8'h00, 8'h10, 8'h12, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0, 8'h00}, // R4
    '{3'b001, 3'b000, 8'h12, 8'h00, 8'h00, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0, 8'h00}, // R4
    '{3'b110, 3'b110, 8'h00, 8'h30, 8'h40, 1'b0, 8'h00, 3'b010, 3'b000, 1'b1, 8'h30}, // R5
    '{3'b001, 3'b001, 8'h30, 8'h00, 8'h00, 1'b1, 8'h50, 3'b000, 3'b000, 1'b1, 8'h50}, // R8
    '{3'b001, 3'b001, 8'h30, 8'h00, 8'h00, 1'b1, 8'h11, 3'b001, 3'b010, 1'b1, 8'h30}, // R6 R9
    '{3'b001, 3'b001, 8'h12, 8'h00, 8'h00, 1'b1, 8'h12, 3'b000, 3'b100, 1'b0, 8'h00}, // R7
    '{3'b111, 3'b111, 8'h11, 8'h35, 8'h31, 1'b0, 8'h00, 3'b011, 3'b010, 1'b1, 8'h35}, // R10
    '{3'b100, 3'b100, 8'h00, 8'h00, 8'h05, 1'b0, 8'h00, 3'b000, 3'b000, 1'b0, 8'h00}, // R4
    '{3'b011, 3'b011, 8'h11, 8'h12, 8'h00, 1'b1, 8'h12, 3'b001, 3'b110, 1'b0, 8'h00}  // R7
  };
  localparam string TAG [12] = '{"R2", "R3", "R3", "R4", "R4", "R5", "R8", "R6",
                                 "R7", "R10", "R4", "R7"};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_vld = '0; req_rdy = '0; req_dst = '0; up_vld = 1'b0; up_addr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) req_dat[i] = DW'(16'hA100 + i);
    up_dat = 16'hBEEF;
    // R1: reset with every input active
    req_vld = '1; req_rdy = '1;
    req_dst[0] = 8'h12; req_dst[1] = 8'h30; req_dst[2] = 8'h40;
    up_vld = 1'b1; up_addr = 8'h11;
    repeat (3) @(negedge clk);
    chk("R1 gnt", 32'(gnt_o), 0);
    chk("R1 dlv", 32'(dlv_vld_o), 0);
    chk("R1 dnv", 32'(dn_vld_o), 0);
    idle();
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < 12; k++) begin
      req_vld = TBL[k].v; req_rdy = TBL[k].r;
      req_dst[0] = TBL[k].d0; req_dst[1] = TBL[k].d1; req_dst[2] = TBL[k].d2;
      up_vld = TBL[k].uv; up_addr = TBL[k].ua;
      @(negedge clk);
      chk({TAG[k], " gnt"}, 32'(gnt_o), 32'(TBL[k].eg));
      chk({TAG[k], " dlv"}, 32'(dlv_vld_o), 32'(TBL[k].ed));
      chk({TAG[k], " dnv"}, 32'(dn_vld_o), 32'(TBL[k].en));
      if (TBL[k].en) chk({TAG[k], " dna"}, 32'(dn_addr_o), 32'(TBL[k].ea));
    end

    // R2: local data lands on the destination member
    idle(); req_vld = 3'b001; req_rdy = 3'b001; req_dst[0] = 8'h12;
    @(negedge clk);
    chk("R2 data", 32'(dlv_dat_o[2]), 32'h0000A100);

    // R3: leftmost source's data chosen at a shared destination
    idle(); req_vld = 3'b011; req_rdy = 3'b011; req_dst[0] = 8'h12; req_dst[1] = 8'h12;
    @(negedge clk);
    chk("R3 data", 32'(dlv_dat_o[2]), 32'h0000A100);

    // R6: bus data replaces a local request at the same member, no downstream copy
    idle(); req_vld = 3'b010; req_rdy = 3'b010; req_dst[1] = 8'h12;
    up_vld = 1'b1; up_addr = 8'h12;
    @(negedge clk);
    chk("R6 data", 32'(dlv_dat_o[2]), 32'h0000BEEF);
    chk("R6 dnv", 32'(dn_vld_o), 0);
    chk("R7 held", 32'(gnt_o), 0);

    // R9: selected outgoing request drives downstream data
    idle(); req_vld = 3'b100; req_rdy = 3'b100; req_dst[2] = 8'h44;
    @(negedge clk);
    chk("R9 dna", 32'(dn_addr_o), 32'h44);
    chk("R9 dnd", 32'(dn_dat_o), 32'h0000A102);

    // R8: pass-through data unchanged
    idle(); up_vld = 1'b1; up_addr = 8'h70;
    @(negedge clk);
    chk("R8 dnd", 32'(dn_dat_o), 32'h0000BEEF);

    // R1: reset in mid-run clears outputs
    idle(); req_vld = 3'b001; req_rdy = 3'b001; req_dst[0] = 8'h30; rst = 1'b1;
    @(negedge clk);
    chk("R1 mid gnt", 32'(gnt_o), 0);
    chk("R1 mid dnv", 32'(dn_vld_o), 0);
    rst = 1'b0; idle();
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule